// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block turns one 32-bit instruction word into the control bundle of a simple single-issue load/store core. It is purely combinational. It splits the word into register indices, a shift amount, a 16-bit constant and a 26-bit jump target. It then looks up the primary opcode, and for register-format words the function code, to produce the ALU operation, the destination register, the write enables, the way the constant is extended, and the branch and jump flags.

The decoder knows three layouts. Register format carries three register indices, a shift amount and a function code. Immediate format carries two indices and a 16-bit constant. Jump format carries a 26-bit target. Any opcode or function code outside the supported set raises an illegal flag and turns off every enable, so a trap unit downstream can act on the flag without first cancelling side effects.

Top module: `insn_decode`

## Requirements
- R1: Field positions: rs_idx_o = insn[25:21], rt_idx_o = insn[20:16], shamt_o = insn[10:6], jump_target_o = insn[25:0], for every word.
- R2: With opcode insn[31:26] = 0, the function code insn[5:0] selects alu_op_o as follows: 32 add → 0, 34 sub → 1, 36 and → 2, 37 or → 3, 39 nor → 4, 42 slt → 5, 0 shift-left → 6. For function code 8 (register jump), jump_o = 1 and jump_reg_o = 1.
- R3: Opcodes map to alu_op_o as follows: 35 load and 43 store → 0 (add); 4 and 5 branches → 1 (sub); 8 add-immediate → 0; 10 set-less-immediate → 5; 12 and-immediate → 2; 13 or-immediate → 3; 15 load-upper → 7 (pass operand B); 3 jump-and-link → 8 (link). Every other case, including an illegal word, gives 0.
- R4: The destination code dst_sel_o is 0 (rd = insn[15:11]), 1 (rt) or 2 (register 31), and dst_idx_o carries the selected index. Register-format ALU words write rd. Load, add-immediate, set-less-immediate, and-immediate, or-immediate and load-upper write rt. Jump-and-link writes register 31. reg_we_o is 1 for exactly these words; words that do not write use code 0.
- R5: ext_mode_o is 0 for sign extension, 1 for zero extension and 2 for upper placement. Add-immediate, set-less-immediate, load, store and both branches use 0. And-immediate and or-immediate use 1. Load-upper uses 2, which places the constant in bits 31:16 with zeros below. All other words use 0. imm_ext_o is the constant extended in the selected mode.
- R6: mem_rd_o is 1 only for opcode 35 and mem_wr_o is 1 only for opcode 43.
- R7: branch_eq_o is 1 only for opcode 4 and branch_ne_o only for opcode 5. jump_o is 1 for opcodes 2 and 3 and for register jump. jump_reg_o is 1 only for register jump.
- R8: Any opcode, or any register-format function code, that is not listed above sets illegal_o. An illegal word drives reg_we_o, mem_rd_o, mem_wr_o, branch_eq_o, branch_ne_o, jump_o and jump_reg_o to 0.
- R9: The word 0x00AF8020 decodes as a register add with rs = 5, rt = 15, destination index 16 and reg_we_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word |
| rs_idx_o | output | 5 | First source register index |
| rt_idx_o | output | 5 | Second source register index |
| dst_idx_o | output | 5 | Resolved destination register index |
| shamt_o | output | 5 | Shift amount field |
| imm_ext_o | output | 32 | Extended 16-bit constant |
| jump_target_o | output | 26 | Jump target field |
| alu_op_o | output | 4 | ALU operation code |
| dst_sel_o | output | 2 | Destination select code |
| ext_mode_o | output | 2 | Constant extension mode |
| reg_we_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| branch_eq_o | output | 1 | Branch if equal |
| branch_ne_o | output | 1 | Branch if not equal |
| jump_o | output | 1 | Unconditional jump |
| jump_reg_o | output | 1 | Jump target comes from a register |
| illegal_o | output | 1 | Unsupported instruction |

## Verification
The assertions watch the structural rules on every evaluation: a read and a write are never requested together, at most one control-flow flag is raised, an illegal word raises no enable, a write to register 31 only comes with a jump, and the extended constant agrees with its mode. Only the bench scenarios can show that each opcode and function code maps to the right ALU code, destination and extension mode. Those scenarios mix random words with directed corner cases: the reference add word, a negative constant, a constant with its top bit set under zero extension, load-upper, and unused opcode and function codes.

// File: rtl/insn_pkg.sv
package insn_pkg;

  localparam int XLEN     = 32;
  localparam int REG_W    = 5;
  localparam int OPC_W    = 6;
  localparam int FN_W     = 6;
  localparam int IMM_W    = 16;
  localparam int TGT_W    = 26;
  localparam int LINK_REG = (1 << REG_W) - 1;

  localparam int OPC_LSB = XLEN - OPC_W;
  localparam int RS_LSB  = OPC_LSB - REG_W;
  localparam int RT_LSB  = RS_LSB - REG_W;
  localparam int RD_LSB  = RT_LSB - REG_W;
  localparam int SH_LSB  = RD_LSB - REG_W;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_AND  = 4'd2,
    ALU_OR   = 4'd3,
    ALU_NOR  = 4'd4,
    ALU_SLT  = 4'd5,
    ALU_SLL  = 4'd6,
    ALU_PASSB = 4'd7,
    ALU_LINK = 4'd8
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_RD   = 2'd0,
    DST_RT   = 2'd1,
    DST_LINK = 2'd2
  } dst_sel_e;

  typedef enum logic [1:0] {
    EXT_SIGN  = 2'd0,
    EXT_ZERO  = 2'd1,
    EXT_UPPER = 2'd2
  } ext_mode_e;

  localparam logic [OPC_W-1:0] OP_REG  = 6'd0;
  localparam logic [OPC_W-1:0] OP_J    = 6'd2;
  localparam logic [OPC_W-1:0] OP_JAL  = 6'd3;
  localparam logic [OPC_W-1:0] OP_BEQ  = 6'd4;
  localparam logic [OPC_W-1:0] OP_BNE  = 6'd5;
  localparam logic [OPC_W-1:0] OP_ADDI = 6'd8;
  localparam logic [OPC_W-1:0] OP_SLTI = 6'd10;
  localparam logic [OPC_W-1:0] OP_ANDI = 6'd12;
  localparam logic [OPC_W-1:0] OP_ORI  = 6'd13;
  localparam logic [OPC_W-1:0] OP_LUI  = 6'd15;
  localparam logic [OPC_W-1:0] OP_LW   = 6'd35;
  localparam logic [OPC_W-1:0] OP_SW   = 6'd43;

  localparam logic [FN_W-1:0] FN_SLL = 6'd0;
  localparam logic [FN_W-1:0] FN_JR  = 6'd8;
  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37;
  localparam logic [FN_W-1:0] FN_NOR = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  typedef struct packed {
    alu_op_e   alu;
    dst_sel_e  dsel;
    ext_mode_e ext;
    logic      reg_we;
    logic      mem_rd;
    logic      mem_wr;
    logic      br_eq;
    logic      br_ne;
    logic      jump;
    logic      jump_reg;
    logic      illegal;
  } ctl_t;

  function automatic ctl_t ctl_idle();
    ctl_t c;
    c.alu      = ALU_ADD;
    c.dsel     = DST_RD;
    c.ext      = EXT_SIGN;
    c.reg_we   = 1'b0;
    c.mem_rd   = 1'b0;
    c.mem_wr   = 1'b0;
    c.br_eq    = 1'b0;
    c.br_ne    = 1'b0;
    c.jump     = 1'b0;
    c.jump_reg = 1'b0;
    c.illegal  = 1'b0;
    return c;
  endfunction

  function automatic ctl_t ctl_bad();
    ctl_t c;
    c = ctl_idle();
    c.illegal = 1'b1;
    return c;
  endfunction

  function automatic ctl_t ctl_write(alu_op_e op, dst_sel_e ds, ext_mode_e ex);
    ctl_t c;
    c = ctl_idle();
    c.alu    = op;
    c.dsel   = ds;
    c.ext    = ex;
    c.reg_we = 1'b1;
    return c;
  endfunction

  function automatic logic [XLEN-1:0] extend_imm(logic [IMM_W-1:0] v, ext_mode_e m);
    logic [XLEN-1:0] r;
    case (m)
      EXT_ZERO:  r = {{(XLEN-IMM_W){1'b0}}, v};
      EXT_UPPER: r = {v, {(XLEN-IMM_W){1'b0}}};
      default:   r = {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/insn_fields.sv
module insn_fields
  import insn_pkg::*;
(
  input  logic [XLEN-1:0]  word_i,
  output logic [OPC_W-1:0] opcode_o,
  output logic [REG_W-1:0] rs_o,
  output logic [REG_W-1:0] rt_o,
  output logic [REG_W-1:0] rd_o,
  output logic [REG_W-1:0] shamt_o,
  output logic [FN_W-1:0]  funct_o,
  output logic [IMM_W-1:0] imm_o,
  output logic [TGT_W-1:0] target_o
);

  assign opcode_o = word_i[XLEN-1 -: OPC_W];
  assign rs_o     = word_i[RS_LSB +: REG_W];
  assign rt_o     = word_i[RT_LSB +: REG_W];
  assign rd_o     = word_i[RD_LSB +: REG_W];
  assign shamt_o  = word_i[SH_LSB +: REG_W];
  assign funct_o  = word_i[FN_W-1:0];
  assign imm_o    = word_i[IMM_W-1:0];
  assign target_o = word_i[TGT_W-1:0];

endmodule

// File: rtl/insn_fn_decode.sv
module insn_fn_decode
  import insn_pkg::*;
(
  input  logic [FN_W-1:0] funct_i,
  output ctl_t            ctl_o
);

  ctl_t c;

  always_comb begin
    case (funct_i)
      FN_ADD: c = ctl_write(ALU_ADD, DST_RD, EXT_SIGN);
      FN_SUB: c = ctl_write(ALU_SUB, DST_RD, EXT_SIGN);
      FN_AND: c = ctl_write(ALU_AND, DST_RD, EXT_SIGN);
      FN_OR:  c = ctl_write(ALU_OR,  DST_RD, EXT_SIGN);
      FN_NOR: c = ctl_write(ALU_NOR, DST_RD, EXT_SIGN);
      FN_SLT: c = ctl_write(ALU_SLT, DST_RD, EXT_SIGN);
      FN_SLL: c = ctl_write(ALU_SLL, DST_RD, EXT_SIGN);
      FN_JR: begin
        c          = ctl_idle();
        c.jump     = 1'b1;
        c.jump_reg = 1'b1;
      end
      default: c = ctl_bad();
    endcase
  end

  assign ctl_o = c;

  always_comb begin
    // R4
    fn_dst_rd_chk: assert (!c.reg_we || c.dsel == DST_RD);
  end

endmodule

// File: rtl/insn_op_decode.sv
module insn_op_decode
  import insn_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  ctl_t             fn_ctl_i,
  output ctl_t             ctl_o
);

  ctl_t c;

  always_comb begin
    case (opcode_i)
      OP_REG:  c = fn_ctl_i;
      OP_LW: begin
        c        = ctl_write(ALU_ADD, DST_RT, EXT_SIGN);
        c.mem_rd = 1'b1;
      end
      OP_SW: begin
        c        = ctl_idle();
        c.mem_wr = 1'b1;
      end
      OP_BEQ: begin
        c       = ctl_idle();
        c.alu   = ALU_SUB;
        c.br_eq = 1'b1;
      end
      OP_BNE: begin
        c       = ctl_idle();
        c.alu   = ALU_SUB;
        c.br_ne = 1'b1;
      end
      OP_J: begin
        c      = ctl_idle();
        c.jump = 1'b1;
      end
      OP_JAL: begin
        c      = ctl_write(ALU_LINK, DST_LINK, EXT_SIGN);
        c.jump = 1'b1;
      end
      OP_ADDI: c = ctl_write(ALU_ADD,   DST_RT, EXT_SIGN);
      OP_SLTI: c = ctl_write(ALU_SLT,   DST_RT, EXT_SIGN);
      OP_ANDI: c = ctl_write(ALU_AND,   DST_RT, EXT_ZERO);
      OP_ORI:  c = ctl_write(ALU_OR,    DST_RT, EXT_ZERO);
      OP_LUI:  c = ctl_write(ALU_PASSB, DST_RT, EXT_UPPER);
      default: c = ctl_bad();
    endcase
  end

  assign ctl_o = c;

  always_comb begin
    // R8
    illegal_quiet_chk: assert (!c.illegal ||
      !(c.reg_we || c.mem_rd || c.mem_wr || c.br_eq || c.br_ne || c.jump || c.jump_reg));
    // R6
    mem_excl_chk: assert (!(c.mem_rd && c.mem_wr));
    // R7
    flow_onehot_chk: assert ($onehot0({c.br_eq, c.br_ne, c.jump}));
  end

endmodule

// File: rtl/insn_imm_extend.sv
module insn_imm_extend
  import insn_pkg::*;
(
  input  logic [IMM_W-1:0] imm_i,
  input  ext_mode_e        mode_i,
  output logic [XLEN-1:0]  imm_o
);

  assign imm_o = extend_imm(imm_i, mode_i);

  always_comb begin
    // R5
    ext_zero_chk: assert (mode_i != EXT_ZERO || imm_o[XLEN-1:IMM_W] == '0);
    // R5
    ext_upper_chk: assert (mode_i != EXT_UPPER ||
      (imm_o[IMM_W-1:0] == '0 && imm_o[XLEN-1 -: IMM_W] == imm_i));
    // R5
    ext_sign_chk: assert (mode_i != EXT_SIGN ||
      (imm_o[IMM_W-1:0] == imm_i && (imm_o[XLEN-1:IMM_W-1] == '0 || &imm_o[XLEN-1:IMM_W-1])));
  end

endmodule

// File: rtl/insn_decode.sv
module insn_decode
  import insn_pkg::*;
(
  input  logic [31:0] insn_i,
  output logic [4:0]  rs_idx_o,
  output logic [4:0]  rt_idx_o,
  output logic [4:0]  dst_idx_o,
  output logic [4:0]  shamt_o,
  output logic [31:0] imm_ext_o,
  output logic [25:0] jump_target_o,
  output logic [3:0]  alu_op_o,
  output logic [1:0]  dst_sel_o,
  output logic [1:0]  ext_mode_o,
  output logic        reg_we_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic        branch_eq_o,
  output logic        branch_ne_o,
  output logic        jump_o,
  output logic        jump_reg_o,
  output logic        illegal_o
);

  logic [OPC_W-1:0] opcode;
  logic [REG_W-1:0] rs, rt, rd, shamt;
  logic [FN_W-1:0]  funct;
  logic [IMM_W-1:0] imm16;
  logic [TGT_W-1:0] target;
  ctl_t             fn_ctl, ctl;
  logic [REG_W-1:0] dst_idx;

  insn_fields u_fields (
    .word_i   (insn_i),
    .opcode_o (opcode),
    .rs_o     (rs),
    .rt_o     (rt),
    .rd_o     (rd),
    .shamt_o  (shamt),
    .funct_o  (funct),
    .imm_o    (imm16),
    .target_o (target)
  );

  insn_fn_decode u_fn (
    .funct_i (funct),
    .ctl_o   (fn_ctl)
  );

  insn_op_decode u_op (
    .opcode_i (opcode),
    .fn_ctl_i (fn_ctl),
    .ctl_o    (ctl)
  );

  insn_imm_extend u_ext (
    .imm_i  (imm16),
    .mode_i (ctl.ext),
    .imm_o  (imm_ext_o)
  );

  always_comb begin
    case (ctl.dsel)
      DST_RT:   dst_idx = rt;
      DST_LINK: dst_idx = REG_W'(LINK_REG);
      default:  dst_idx = rd;
    endcase
  end

  assign rs_idx_o      = rs;
  assign rt_idx_o      = rt;
  assign dst_idx_o     = dst_idx;
  assign shamt_o       = shamt;
  assign jump_target_o = target;
  assign alu_op_o      = ctl.alu;
  assign dst_sel_o     = ctl.dsel;
  assign ext_mode_o    = ctl.ext;
  assign reg_we_o      = ctl.reg_we;
  assign mem_rd_o      = ctl.mem_rd;
  assign mem_wr_o      = ctl.mem_wr;
  assign branch_eq_o   = ctl.br_eq;
  assign branch_ne_o   = ctl.br_ne;
  assign jump_o        = ctl.jump;
  assign jump_reg_o    = ctl.jump_reg;
  assign illegal_o     = ctl.illegal;

  always_comb begin
    // R4
    link_write_chk: assert (!(reg_we_o && dst_idx_o == 5'd31 && dst_sel_o == 2'd2) || jump_o);
    // R7
    jreg_implies_jump_chk: assert (!jump_reg_o || (jump_o && !reg_we_o));
    // R9
    ref_word_chk: assert (insn_i != 32'h00AF8020 ||
      (alu_op_o == 4'd0 && dst_idx_o == 5'd16 && rs_idx_o == 5'd5 && rt_idx_o == 5'd15 && reg_we_o));
  end

endmodule

// File: tb/test_insn_decode.sv
module test_insn_decode;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] insn;
  logic [4:0]  rs_idx, rt_idx, dst_idx, shamt;
  logic [31:0] imm_ext;
  logic [25:0] jtgt;
  logic [3:0]  alu_op;
  logic [1:0]  dst_sel, ext_mode;
  logic        reg_we, mem_rd, mem_wr, beq, bne, jmp, jreg, ill;

  insn_decode i_insn_decode (
    .insn_i        (insn),
    .rs_idx_o      (rs_idx),
    .rt_idx_o      (rt_idx),
    .dst_idx_o     (dst_idx),
    .shamt_o       (shamt),
    .imm_ext_o     (imm_ext),
    .jump_target_o (jtgt),
    .alu_op_o      (alu_op),
    .dst_sel_o     (dst_sel),
    .ext_mode_o    (ext_mode),
    .reg_we_o      (reg_we),
    .mem_rd_o      (mem_rd),
    .mem_wr_o      (mem_wr),
    .branch_eq_o   (beq),
    .branch_ne_o   (bne),
    .jump_o        (jmp),
    .jump_reg_o    (jreg),
    .illegal_o     (ill)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit vec_bad;

  typedef struct {
    logic [3:0]  alu;
    logic [1:0]  dsel;
    logic [1:0]  ext;
    logic        we, mrd, mwr, beq, bne, jmp, jreg, ill;
    logic [4:0]  dst;
    logic [31:0] imm;
  } exp_t;

  function automatic exp_t model(input logic [31:0] w);
    exp_t e;
    int op, fn;
    op = int'(w[31:26]);
    fn = int'(w[5:0]);
    e = '{alu: 4'd0, dsel: 2'd0, ext: 2'd0, we: 1'b0, mrd: 1'b0, mwr: 1'b0,
          beq: 1'b0, bne: 1'b0, jmp: 1'b0, jreg: 1'b0, ill: 1'b0, dst: 5'd0, imm: 32'd0};
    if (op == 0) begin
      e.we = 1'b1;
      if      (fn == 32) e.alu = 4'd0;
      else if (fn == 34) e.alu = 4'd1;
      else if (fn == 36) e.alu = 4'd2;
      else if (fn == 37) e.alu = 4'd3;
      else if (fn == 39) e.alu = 4'd4;
      else if (fn == 42) e.alu = 4'd5;
      else if (fn == 0)  e.alu = 4'd6;
      else if (fn == 8)  begin e.we = 1'b0; e.jmp = 1'b1; e.jreg = 1'b1; end
      else begin e.we = 1'b0; e.ill = 1'b1; end
    end else if (op == 35) begin e.we = 1; e.dsel = 1; e.mrd = 1; end
    else if (op == 43) e.mwr = 1;
    else if (op == 4) begin e.alu = 1; e.beq = 1; end
    else if (op == 5) begin e.alu = 1; e.bne = 1; end
    else if (op == 2) e.jmp = 1;
    else if (op == 3) begin e.jmp = 1; e.we = 1; e.dsel = 2; e.alu = 8; end
    else if (op == 8)  begin e.we = 1; e.dsel = 1; end
    else if (op == 10) begin e.we = 1; e.dsel = 1; e.alu = 5; end
    else if (op == 12) begin e.we = 1; e.dsel = 1; e.alu = 2; e.ext = 1; end
    else if (op == 13) begin e.we = 1; e.dsel = 1; e.alu = 3; e.ext = 1; end
    else if (op == 15) begin e.we = 1; e.dsel = 1; e.alu = 7; e.ext = 2; end
    else e.ill = 1'b1;
    e.dst = (e.dsel == 2'd1) ? w[20:16] : (e.dsel == 2'd2) ? 5'd31 : w[15:11];
    if (e.ext == 2'd1)      e.imm = {16'h0000, w[15:0]};
    else if (e.ext == 2'd2) e.imm = {w[15:0], 16'h0000};
    else                    e.imm = w[15] ? {16'hFFFF, w[15:0]} : {16'h0000, w[15:0]};
    return e;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp, input logic [31:0] w);
    if (act !== exp) begin
      vec_bad = 1'b1;
      $display("FAIL %s %s insn=%08h actual=%0h expected=%0h", tag, what, w, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    exp_t e;
    @(negedge clk);
    insn = w;
    #1;
    e = model(w);
    vec_bad = 1'b0;
    cmp("R1", "rs",     32'(rs_idx), 32'(w[25:21]), w);
    cmp("R1", "rt",     32'(rt_idx), 32'(w[20:16]), w);
    cmp("R1", "shamt",  32'(shamt),  32'(w[10:6]), w);
    cmp("R1", "target", 32'(jtgt),   32'(w[25:0]), w);
    cmp(w[31:26] == 6'd0 ? "R2" : "R3", "alu_op", 32'(alu_op), 32'(e.alu), w);
    cmp("R4", "dst_sel", 32'(dst_sel), 32'(e.dsel), w);
    cmp("R4", "dst_idx", 32'(dst_idx), 32'(e.dst), w);
    cmp("R4", "reg_we",  32'(reg_we),  32'(e.we), w);
    cmp("R5", "ext_mode", 32'(ext_mode), 32'(e.ext), w);
    cmp("R5", "imm_ext", imm_ext, e.imm, w);
    cmp("R6", "mem_rd", 32'(mem_rd), 32'(e.mrd), w);
    cmp("R6", "mem_wr", 32'(mem_wr), 32'(e.mwr), w);
    cmp("R7", "br_eq",  32'(beq),  32'(e.beq), w);
    cmp("R7", "br_ne",  32'(bne),  32'(e.bne), w);
    cmp("R7", "jump",   32'(jmp),  32'(e.jmp), w);
    cmp("R7", "jreg",   32'(jreg), 32'(e.jreg), w);
    cmp("R8", "illegal", 32'(ill), 32'(e.ill), w);
    n_vec++;
    if (vec_bad) n_bad++;
  endtask

  logic [5:0] legal_op [12] = '{6'd0, 6'd2, 6'd3, 6'd4, 6'd5, 6'd8, 6'd10, 6'd12, 6'd13, 6'd15, 6'd35, 6'd43};
  logic [5:0] legal_fn [8]  = '{6'd0, 6'd8, 6'd32, 6'd34, 6'd36, 6'd37, 6'd39, 6'd42};

  initial begin
    #400000;
    $display("FAIL watchdog expired");
    n_bad++;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    insn = 32'h0;
    void'($urandom(32'd20240611));
    // reset state: all-zero word is a shift-left writing rd 0
    repeat (2) @(posedge clk);
    apply(32'h0000_0000);
    rst_n = 1'b1;
    // R9 reference add word
    apply(32'h00AF8020);
    if (alu_op !== 4'd0 || dst_idx !== 5'd16 || rs_idx !== 5'd5 || rt_idx !== 5'd15 || reg_we !== 1'b1) begin
      $display("FAIL R9 add decode actual=%0h/%0d expected=0/16", alu_op, dst_idx);
      n_bad++;
    end
    n_vec++;
    // R5 negative constant on add-immediate, top-bit constants on and/or-immediate, load-upper
    apply({6'd8,  5'd1, 5'd2, 16'hFFF0});
    apply({6'd12, 5'd3, 5'd4, 16'h8001});
    apply({6'd13, 5'd3, 5'd4, 16'hFFFF});
    apply({6'd15, 5'd0, 5'd9, 16'h8000});
    apply({6'd10, 5'd7, 5'd8, 16'h8000});
    // R6 load and store
    apply({6'd35, 5'd9, 5'd8, 16'd1200});
    apply({6'd43, 5'd9, 5'd8, 16'd1200});
    // R7 branches and jumps
    apply({6'd4, 5'd16, 5'd17, 16'hFFFE});
    apply({6'd5, 5'd16, 5'd17, 16'h0003});
    apply({6'd2, 26'h3FF_FFFF});
    apply({6'd3, 26'h000_1234});
    apply({6'd0, 5'd31, 15'd0, 6'd8});
    // R8 unused opcode and function codes
    apply({6'd63, 26'h3FF_FFFF});
    apply({6'd1,  26'h000_0000});
    apply({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'd1});
    apply({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'd63});
    // constrained random
    for (int k = 0; k < 4000; k++) begin
      w = $urandom;
      if (($urandom % 8) != 0) w[31:26] = legal_op[$urandom % 12];
      if (w[31:26] == 6'd0 && ($urandom % 6) != 0) w[5:0] = legal_fn[$urandom % 8];
      apply(w);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule